// File: doc/BRIEF.md
# Seven-Bit Bidirectional GPIO Port

This block is a small memory-mapped general-purpose I/O port of seven pins. Software controls it through three registers on a simple register bus: a direction register, a pin register, and an output latch register. The pin register reads the pin levels, after a two-flop synchronizer. The latch register reads back the stored output value, which keeps read-modify-write sequences on the outputs safe. A write to either the pin address or the latch address loads the same data latch. For each pin the block drives a tri-state output value and an output enable toward the pad.

Three pins behave in special ways. Pin 4 is an open-drain output: it can pull low but never drives high. Pin 6 works as general I/O only while a clock-mode input reports one of two modes that free the pin. Each pin can also be placed in analog mode through an analog-select input vector. An analog pin reads as zero, but its direction bit still controls its driver, so software keeps that bit set. Register reads are registered and appear on the read bus one cycle after the address is presented.

Top module: `gpio_bidir_port`

## Requirements
- R1: Direction register at address 2: bit value 1 makes the pin an input (pin_oe low); bit value 0 enables the driver with the latch bit on pin_o. Writing 0xCF there makes pins 3:0 inputs and pins 5:4 outputs.
- R2: A read of address 0 returns the pin levels after two synchronizer flops. A level applied to pin_i before clock edge k is visible on rd_data after edge k+2, when address 0 is held.
- R3: A read of address 1 returns the latched output value and never the pin levels.
- R4: A write to address 0 or address 1 loads the same data latch with wr_data[6:0].
- R5: Pin 4 is open drain: with direction bit 0 and latch bit 0, pin_oe[4]=1 and pin_o[4]=0. With latch bit 1, pin_oe[4]=0. Pin 4 is never driven high.
- R6: Pin 6 is general I/O only while clk_mode is 3'd5 or 3'd6. In any other mode pin_oe[6]=0 and a read of address 0 returns 0 in bit 6.
- R7: Where analog_sel[i]=1, bit i of an address-0 read is 0. The direction bit still controls pin_oe[i]. After reset the bench holds analog_sel at 7'b0101111.
- R8: After reset the direction register holds 7'h7F, the latch holds 0 and rd_data is 0. Bit 7 of every register reads as 0 and ignores writes. Address 3 reads as 0. rd_data is registered one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register select: 0 pins, 1 latch, 2 direction, 3 unused |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| analog_sel | input | 7 | Per-pin analog-mode select |
| clk_mode | input | 3 | Clock-mode code; 5 or 6 frees pin 6 |
| pin_i | input | 7 | Pad input levels (asynchronous) |
| pin_o | output | 7 | Pad output values |
| pin_oe | output | 7 | Pad output enables |

## Verification
A corrupted direction or latch bit shows on pin_oe or pin_o in the cycle after the write that caused it. It also shows on the next read of address 1 or 2, one cycle after that address is presented. A synchronizer with a missing or extra stage shifts pin changes on an address-0 read by one cycle, which the per-clock reference comparison catches. A wrong analog or clock-mode mask leaves a stray 1 in a port read the cycle after the read is issued.

// File: rtl/gpio_port_pkg.sv
// Package: shared register selects and bus widths for the GPIO port.
// Assumes a two-bit register address and a byte-wide bus.
package gpio_port_pkg;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PINS  = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for the asynchronous pad inputs.
// Assumes STAGES >= 1; every stage resets to zero.
module gpio_in_sync #(
    parameter int unsigned W      = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];

    // first stage captures the raw pad levels
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= async_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // each later stage re-registers the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_ctl_regs.sv
// Module: direction and output-latch registers with their write decode.
// Assumes BUS_W > W; the bus bits above W are dropped on write.
module gpio_ctl_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     lat_q
);
    logic sel_lat;
    logic sel_dir;

    // pin and latch addresses share one data latch
    always_comb begin
        sel_lat = wr_en && ((addr == SEL_PINS) || (addr == SEL_LATCH));
        sel_dir = wr_en && (addr == SEL_DIR);
    end

    // direction register: all pins inputs out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_q <= '1;
        else if (sel_dir) dir_q <= wr_data[W-1:0];
    end

    // output data latch: cleared out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_q <= '0;
        else if (sel_lat) lat_q <= wr_data[W-1:0];
    end
endmodule

// File: rtl/gpio_pad_drive.sv
// Module: per-pin tri-state control for the pads.
// Assumes OD_BIT and GATED_BIT are distinct pins below W.
module gpio_pad_drive #(
    parameter int unsigned W         = 7,
    parameter int unsigned OD_BIT    = 4,
    parameter int unsigned GATED_BIT = 6
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lat_q,
    input  logic         gated_en,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] pin_oe
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            if (i == OD_BIT) begin : g_od
                // open drain: pull low only, release on a latched one
                always_comb begin
                    pin_o[i]  = 1'b0;
                    pin_oe[i] = ~dir_q[i] & ~lat_q[i];
                end
            end else if (i == GATED_BIT) begin : g_gated
                // clock-mode gated pin: driver held off unless freed
                always_comb begin
                    pin_o[i]  = lat_q[i];
                    pin_oe[i] = ~dir_q[i] & gated_en;
                end
            end else begin : g_push
                // ordinary push-pull pin
                always_comb begin
                    pin_o[i]  = lat_q[i];
                    pin_oe[i] = ~dir_q[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_read_path.sv
// Module: registered read multiplexer with analog and gated-pin masking.
// Assumes BUS_W > W; the upper bus bits always read zero.
module gpio_read_path
    import gpio_port_pkg::*;
#(
    parameter int unsigned W         = 7,
    parameter int unsigned GATED_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      pins_sync,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      lat_q,
    input  logic [W-1:0]      analog_sel,
    input  logic              gated_en,
    output logic [BUS_W-1:0]  rd_data
);
    localparam int unsigned PAD_W = BUS_W - W;

    logic [W-1:0] pin_mask;
    logic [W-1:0] rd_sel;

    // digital pins pass, analog and unfreed gated pins read zero
    always_comb begin
        pin_mask = ~analog_sel;
        if (!gated_en) pin_mask[GATED_BIT] = 1'b0;
    end

    // pick the addressed register
    always_comb begin
        case (addr)
            SEL_PINS:  rd_sel = pins_sync & pin_mask;
            SEL_LATCH: rd_sel = lat_q;
            SEL_DIR:   rd_sel = dir_q;
            default:   rd_sel = '0;
        endcase
    end

    // one cycle of read latency
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= {{PAD_W{1'b0}}, rd_sel};
    end
endmodule

// File: rtl/gpio_bidir_port.sv
// Module: top of the seven-pin bidirectional GPIO port.
// Assumes pin_i is asynchronous; all other inputs are synchronous to clk.
module gpio_bidir_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned W          = 7,
    parameter int unsigned SYNC_STG   = 2,
    parameter int unsigned OD_BIT     = 4,
    parameter int unsigned GATED_BIT  = 6,
    parameter int unsigned MODE_W     = 3,
    parameter int unsigned FREE_MODE_A = 5,
    parameter int unsigned FREE_MODE_B = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [6:0]        analog_sel,
    input  logic [2:0]        clk_mode,
    input  logic [6:0]        pin_i,
    output logic [6:0]        pin_o,
    output logic [6:0]        pin_oe
);
    logic [W-1:0] dir_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] pins_sync;
    logic         gated_en;

    // the gated pin is freed by either of two clock modes
    always_comb begin
        gated_en = (clk_mode == MODE_W'(FREE_MODE_A)) ||
                   (clk_mode == MODE_W'(FREE_MODE_B));
    end

    gpio_in_sync #(.W(W), .STAGES(SYNC_STG)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (pins_sync)
    );

    gpio_ctl_regs #(.W(W)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .dir_q  (dir_q),
        .lat_q  (lat_q)
    );

    gpio_pad_drive #(.W(W), .OD_BIT(OD_BIT), .GATED_BIT(GATED_BIT)) drv_i (
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .gated_en(gated_en),
        .pin_o   (pin_o),
        .pin_oe  (pin_oe)
    );

    gpio_read_path #(.W(W), .GATED_BIT(GATED_BIT)) rd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .pins_sync (pins_sync),
        .dir_q     (dir_q),
        .lat_q     (lat_q),
        .analog_sel(analog_sel),
        .gated_en  (gated_en),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/gpio_bidir_port_chk.sv
// Module: assertion checker bound to the GPIO port top.
// Assumes the default pin roles (open drain on 4, gated pin 6, modes 5 and 6).
module gpio_bidir_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [6:0] analog_sel,
    input logic [2:0] clk_mode,
    input logic [6:0] pin_o,
    input logic [6:0] pin_oe
);
    logic mode_free;
    assign mode_free = (clk_mode == 3'd5) || (clk_mode == 3'd6);

    AST_DIR_SETS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> (pin_oe[3:0] == ~$past(wr_data[3:0]))); // R1

    AST_LATCH_BOTH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 2'd0 || addr == 2'd1)) |=> (pin_o[3:0] == $past(wr_data[3:0]))); // R4

    AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 2'd0 || addr == 2'd1) && wr_data[4]) |=> !pin_oe[4]); // R5

    AST_GATED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_free |-> !pin_oe[6]); // R6

    AST_GATED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_free && addr == 2'd0) |=> !rd_data[6]); // R6

    AST_ANALOG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd0 && analog_sel[0]) |=> !rd_data[0]); // R7

    AST_UNUSED_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd3) |=> (rd_data == 8'h00)); // R8
endmodule

bind gpio_bidir_port gpio_bidir_port_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .analog_sel(analog_sel),
    .clk_mode  (clk_mode),
    .pin_o     (pin_o),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_bidir_port_tb_top.sv
// Bench: behavioural per-clock reference model plus directed and random stimulus.
module gpio_bidir_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd3;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [6:0] analog_sel = 7'b0101111;
    logic [2:0] clk_mode = 3'd0;
    logic [6:0] pin_i = 7'h00;
    logic [6:0] pin_o;
    logic [6:0] pin_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit model_ok = 0;

    // reference state
    int m_dir;
    int m_lat;
    int exp_rd;
    logic [6:0] hist[$];

    always #2 clk = ~clk;

    gpio_bidir_port dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .analog_sel(analog_sel),
        .clk_mode(clk_mode), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    function automatic bit freed();
        return (clk_mode == 3'd5) || (clk_mode == 3'd6);
    endfunction

    // reference model: advances once per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 'h7F; m_lat = 0; exp_rd = 0;
            hist = '{7'h00, 7'h00};
        end else begin
            int pv;
            pv = int'(hist[1]) & ~int'(analog_sel) & 'h7F;
            if (!freed()) pv = pv & ~(1 << 6);
            case (addr)
                2'd0: exp_rd = pv;
                2'd1: exp_rd = m_lat;
                2'd2: exp_rd = m_dir;
                default: exp_rd = 0;
            endcase
            if (wr_en && (addr == 2'd0 || addr == 2'd1)) m_lat = int'(wr_data) & 'h7F;
            if (wr_en && addr == 2'd2) m_dir = int'(wr_data) & 'h7F;
            hist.push_front(pin_i);
            void'(hist.pop_back());
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare all outputs against the model
    task automatic compare();
        int eoe;
        eoe = ~m_dir & 'h7F;
        if (m_lat & (1 << 4)) eoe = eoe & ~(1 << 4);
        if (!freed()) eoe = eoe & ~(1 << 6);
        if (addr == 2'd0)      check("R2 port read", int'(rd_data), exp_rd);
        else if (addr == 2'd1) check("R3 latch read", int'(rd_data), exp_rd);
        else                   check("R8 dir/unused read", int'(rd_data), exp_rd);
        check("R1 pin_oe", int'(pin_oe), eoe);
        check("R5 pin_o", int'(pin_o), m_lat & ~(1 << 4));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (model_ok) compare();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        addr = a;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_ok = 1;
        // R8 reset state
        check("R8 reset rd_data", int'(rd_data), 0);
        check("R8 reset pin_oe", int'(pin_oe), 0);
        rd(2'd2);
        check("R8 reset direction", int'(rd_data), 'h7F);
        rd(2'd1);
        check("R8 reset latch", int'(rd_data), 0);

        // R1 direction value 0xCF
        wr(2'd2, 8'hCF);
        check("R1 0xCF pin_oe", int'(pin_oe), 'h30);
        rd(2'd2);
        check("R8 bit7 dropped on dir", int'(rd_data), 'h4F);

        // R4 both addresses write the latch; R3 latch reads ignore pins
        pin_i = 7'h00;
        wr(2'd0, 8'h85);
        rd(2'd1);
        check("R4 latch via port addr", int'(rd_data), 'h05);
        wr(2'd1, 8'h2A);
        rd(2'd1);
        check("R3 latch not pins", int'(rd_data), 'h2A);

        // R5 open drain on pin 4
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h10);
        check("R5 od released", int'(pin_oe[4]), 0);
        wr(2'd1, 8'h00);
        check("R5 od pulls low", int'({pin_oe[4], pin_o[4]}), 2);

        // R2 synchronizer latency, all digital, pin 6 freed
        wr(2'd2, 8'h7F);
        analog_sel = 7'h00; clk_mode = 3'd5;
        addr = 2'd0; pin_i = 7'h00;
        repeat (3) step();
        pin_i = 7'h7F;
        step(); check("R2 not yet after 1 edge", int'(rd_data), 0);
        step(); check("R2 not yet after 2 edges", int'(rd_data), 0);
        step(); check("R2 visible after 3 edges", int'(rd_data), 'h7F);

        // R6 pin 6 gating
        clk_mode = 3'd6; step(); step();
        check("R6 mode 6 frees pin", int'(rd_data[6]), 1);
        clk_mode = 3'd0; step();
        check("R6 other mode reads 0", int'(rd_data[6]), 0);
        wr(2'd2, 8'h00);
        check("R6 no drive when not freed", int'(pin_oe[6]), 0);

        // R7 analog masking, direction still in control
        analog_sel = 7'b0101111; clk_mode = 3'd5;
        rd(2'd0);
        check("R7 analog pins read 0", int'(rd_data), 'h50);
        check("R7 analog pin still driven", int'(pin_oe[0]), 1);
        rd(2'd3);
        check("R8 unused address", int'(rd_data), 0);

        // random phase, checked every clock by the model
        for (int n = 0; n < 600; n++) begin
            addr = 2'($urandom);
            wr_en = 1'($urandom);
            wr_data = 8'($urandom);
            analog_sel = 7'($urandom);
            clk_mode = 3'($urandom);
            pin_i = 7'($urandom);
            step();
        end
        wr_en = 1'b0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule